// File: doc/BRIEF.md
# Hold-to-Ready DMA Bus Bridge

This block lets a DMA controller take the system bus from a processor that has no usable bus-hold input. A bus request from the DMA controller is carried into the processor clock domain, where the bridge pulls the processor's ready line low. The processor then freezes in a wait state and leaves the bus alone. Once the processor side reports that its current bus cycle has ended, a grant travels back to the DMA clock domain. There the bridge raises hold-acknowledge and a DMA-enable strobe together.

The two clocks are unrelated. Each signal that crosses between them passes through a synchronizer with a parameterised number of flip-flop stages, two by default. The request and grant form a four-phase handshake, so a request that is withdrawn early still completes cleanly.

The bridge also produces the ready signal seen by the DMA controller. A transfer cycle that starts while the bus is owned gets a configurable number of inserted wait cycles, one by default. Refresh cycles and cycles outside DMA ownership pass memory ready through with no added wait.

Top module: `hold_ready_bridge`

## Requirements
- R1: While a bus request is in progress or granted, `cpu_ready` is 0 within a bounded number of CPU cycles, and it stays 0 for as long as `hold_ack` is 1.
- R2: `hold_ack` and `dma_en` rise together, and only after `hold_req` was 1 on the previous DMA clock edge.
- R3: Each clock-crossing signal passes through SYNC_STAGES flip-flops (default 2). After the synchronous active-high resets: `cpu_ready`=1, `hold_ack`=0, `dma_en`=0 and `dma_ready`=0.
- R4: `hold_ack` does not assert while `cpu_bus_idle` is 0. It asserts within a bounded time once `cpu_bus_idle` is 1 during a stall.
- R5: On the first DMA clock edge at which `hold_req` is 0, `hold_ack` and `dma_en` fall. `cpu_ready` returns to 1 only later, after the release crosses into the CPU domain.
- R6: If `xfer_start`=1 and `refresh`=0 at a DMA clock edge while `hold_ack`=1, `dma_ready` is 0 for the next EXTRA_WAIT cycles, whatever `mem_ready` is.
- R7: If `refresh`=1 and no inserted wait is pending, `dma_ready` equals the `mem_ready` value from the previous DMA clock edge (zero added waits).
- R8: If `hold_ack`=0 and no inserted wait is pending, `dma_ready` equals `mem_ready` delayed by one DMA cycle, even if `xfer_start`=1.
- R9: A request withdrawn before the grant arrives never raises `hold_ack`. The handshake still completes, and `cpu_ready` returns to 1.
- R10: `hold_ack` and `cpu_ready` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| cpu_bus_idle | input | 1 | 1 when the processor has no bus cycle in flight |
| cpu_ready | output | 1 | Ready to processor; 0 stalls it |
| dma_clk | input | 1 | DMA controller clock, unrelated to cpu_clk |
| dma_rst | input | 1 | Synchronous active-high reset, DMA domain |
| hold_req | input | 1 | Bus request from DMA controller |
| hold_ack | output | 1 | Bus granted to DMA controller |
| dma_en | output | 1 | DMA-enable strobe, asserted with hold_ack |
| xfer_start | input | 1 | First cycle of a DMA memory cycle |
| refresh | input | 1 | Current cycle is a refresh cycle |
| mem_ready | input | 1 | Ready returned by memory |
| dma_ready | output | 1 | Ready presented to the DMA controller |

## Verification
The hardest case to reach is a request withdrawn while the grant is still in flight across the clock boundary. If the handshake does not finish its return-to-zero phase, a stale grant can reach a later request. To get there, the bench holds `cpu_bus_idle` low and raises `hold_req` for only a few DMA cycles. It then frees the bus and issues fresh requests right away. With 4 ns and 7 ns clocks the crossing phases vary from run to run, and a free-running monitor looks for any overlap of `hold_ack` and `cpu_ready`.

// File: rtl/hold_bridge_pkg.sv
package hold_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_OWN   = 2'd2,
    ST_DRAIN = 2'd3
  } dma_state_t;
endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchronizer for one level signal (R3)
module hb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_cpu_side.sv
// CPU-domain half: stalls the processor and reports when the bus is idle
module hb_cpu_side #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stall_req_x,
  input  logic bus_idle,
  output logic cpu_ready,
  output logic grant
);
  logic stall_s;

  hb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(stall_req_x), .q(stall_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b1;
      grant     <= 1'b0;
    end else begin
      cpu_ready <= ~stall_s;
      if (!stall_s)                   grant <= 1'b0;
      else if (!cpu_ready && bus_idle) grant <= 1'b1;
    end
  end

  AST_GRANT_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    grant |-> !cpu_ready); // R1
  AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> $past(bus_idle)); // R4
endmodule

// File: rtl/hb_dma_side.sv
// DMA-domain half: four-phase request/grant handshake and acknowledge outputs
module hb_dma_side
  import hold_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic grant_x,
  output logic stall_req,
  output logic hold_ack,
  output logic dma_en
);
  logic       grant_s;
  dma_state_t state, nxt;

  hb_sync #(.STAGES(SYNC_STAGES)) u_gnt_sync (
    .clk(clk), .rst(rst), .d(grant_x), .q(grant_s)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (hold_req) nxt = ST_REQ;
      ST_REQ:   if (grant_s)  nxt = hold_req ? ST_OWN : ST_DRAIN;
      ST_OWN:   if (!hold_req) nxt = ST_DRAIN;
      ST_DRAIN: if (!grant_s) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stall_req <= 1'b0;
      hold_ack  <= 1'b0;
      dma_en    <= 1'b0;
    end else begin
      state     <= nxt;
      stall_req <= (nxt == ST_REQ) || (nxt == ST_OWN);
      hold_ack  <= (nxt == ST_OWN);
      dma_en    <= (nxt == ST_OWN);
    end
  end

  AST_ACK_HAS_GRANT: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> grant_s); // R4
  AST_ACK_DROPS_FIRST: assert property (@(posedge clk) disable iff (rst)
    !hold_req |=> !hold_ack); // R5
  AST_STALL_COVERS_ACK: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> stall_req); // R1
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(hold_req)); // R2
endmodule

// File: rtl/hb_wait_gen.sv
// Ready shaping toward the DMA controller: inserted waits for bus-owned cycles
module hb_wait_gen #(
  parameter int EXTRA_WAIT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_xfer,
  input  logic xfer_start,
  input  logic refresh,
  input  logic mem_ready,
  output logic dma_ready
);
  localparam int CW = (EXTRA_WAIT < 1) ? 1 : $clog2(EXTRA_WAIT + 1);

  logic [CW-1:0] wcnt;
  logic          arm;

  assign arm = xfer_start && in_xfer && !refresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt      <= '0;
      dma_ready <= 1'b0;
    end else if (arm) begin
      wcnt      <= CW'(EXTRA_WAIT - 1);
      dma_ready <= 1'b0;
    end else if (wcnt != '0) begin
      wcnt      <= wcnt - 1'b1;
      dma_ready <= 1'b0;
    end else begin
      dma_ready <= mem_ready;
    end
  end

  AST_WAIT_ADDED: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && in_xfer && !refresh) |=> !dma_ready); // R6
  AST_REFRESH_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (refresh && wcnt == '0) |=> (dma_ready == $past(mem_ready))); // R7
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!in_xfer && wcnt == '0) |=> (dma_ready == $past(mem_ready))); // R8
endmodule

// File: rtl/hold_ready_bridge.sv
module hold_ready_bridge #(
  parameter int SYNC_STAGES = 2,
  parameter int EXTRA_WAIT  = 1
) (
  input  logic cpu_clk,
  input  logic cpu_rst,
  input  logic cpu_bus_idle,
  output logic cpu_ready,
  input  logic dma_clk,
  input  logic dma_rst,
  input  logic hold_req,
  output logic hold_ack,
  output logic dma_en,
  input  logic xfer_start,
  input  logic refresh,
  input  logic mem_ready,
  output logic dma_ready
);
  logic stall_req;
  logic grant;

  hb_dma_side #(.SYNC_STAGES(SYNC_STAGES)) u_dma (
    .clk(dma_clk), .rst(dma_rst), .hold_req(hold_req), .grant_x(grant),
    .stall_req(stall_req), .hold_ack(hold_ack), .dma_en(dma_en)
  );

  hb_cpu_side #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .clk(cpu_clk), .rst(cpu_rst), .stall_req_x(stall_req),
    .bus_idle(cpu_bus_idle), .cpu_ready(cpu_ready), .grant(grant)
  );

  hb_wait_gen #(.EXTRA_WAIT(EXTRA_WAIT)) u_wait (
    .clk(dma_clk), .rst(dma_rst), .in_xfer(hold_ack), .xfer_start(xfer_start),
    .refresh(refresh), .mem_ready(mem_ready), .dma_ready(dma_ready)
  );

  AST_EN_MATCHES_ACK: assert property (@(posedge dma_clk) disable iff (dma_rst)
    dma_en == hold_ack); // R2
endmodule

// File: tb/sim_hold_ready_bridge.sv
`timescale 1ns/100ps
module sim_hold_ready_bridge;
  localparam int EW = 1;

  logic cpu_clk = 0, dma_clk = 0;
  logic cpu_rst = 1, dma_rst = 1;
  logic cpu_bus_idle = 0, hold_req = 0, xfer_start = 0, refresh = 0, mem_ready = 0;
  logic cpu_ready, hold_ack, dma_en, dma_ready;

  int checks = 0, errors = 0, overlaps = 0;
  bit done = 0;

  always #2   cpu_clk = ~cpu_clk;
  always #3.5 dma_clk = ~dma_clk;

  hold_ready_bridge #(.SYNC_STAGES(2), .EXTRA_WAIT(EW)) u0 (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .cpu_bus_idle(cpu_bus_idle),
    .cpu_ready(cpu_ready), .dma_clk(dma_clk), .dma_rst(dma_rst),
    .hold_req(hold_req), .hold_ack(hold_ack), .dma_en(dma_en),
    .xfer_start(xfer_start), .refresh(refresh), .mem_ready(mem_ready),
    .dma_ready(dma_ready)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic dwait(input int n);
    for (int i = 0; i < n; i++) @(negedge dma_clk);
  endtask

  // R10: free-running overlap monitor
  initial begin
    #50;
    forever begin
      #1;
      if (hold_ack === 1'b1 && cpu_ready === 1'b1) overlaps++;
    end
  end

  // Ready-shaping sweep; ack_phase tells the model whether the bus is owned
  task automatic sweep(input logic ack_phase, input int steps, input string req);
    int pend = 0;
    for (int s = 0; s < steps; s++) begin
      logic st, rf, mr, exp;
      st = s[0]; rf = s[1]; mr = s[2] ^ s[3];
      xfer_start = st; refresh = rf; mem_ready = mr;
      if (st && ack_phase && !rf) begin exp = 1'b0; pend = EW - 1; end
      else if (pend > 0)          begin exp = 1'b0; pend--; end
      else                              exp = mr;
      @(negedge dma_clk);
      chk(req, dma_ready, exp);
    end
    xfer_start = 0; refresh = 0; mem_ready = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic seen;
    dwait(5);
    cpu_rst = 0; dma_rst = 0;
    @(negedge dma_clk);
    chk("R3 reset cpu_ready", cpu_ready, 1'b1);
    chk("R3 reset hold_ack", hold_ack, 1'b0);
    chk("R3 reset dma_en", dma_en, 1'b0);
    chk("R3 reset dma_ready", dma_ready, 1'b0);

    // R8: no ownership, start has no effect
    sweep(1'b0, 16, "R8 pass-through");

    // R1/R4: request while processor busy
    hold_req = 1;
    dwait(20);
    chk("R1 stall asserted", cpu_ready, 1'b0);
    chk("R4 no ack while busy", hold_ack, 1'b0);
    @(negedge cpu_clk) cpu_bus_idle = 1;
    dwait(20);
    chk("R2 ack", hold_ack, 1'b1);
    chk("R2 dma_en", dma_en, 1'b1);
    chk("R1 stall held", cpu_ready, 1'b0);

    // R6/R7 while bus owned
    sweep(1'b1, 16, "R6/R7 owned ready");
    chk("R2 ack held", hold_ack, 1'b1);

    // R5 release order
    hold_req = 0;
    @(negedge dma_clk);
    chk("R5 ack drops", hold_ack, 1'b0);
    chk("R5 en drops", dma_en, 1'b0);
    chk("R5 ready still low", cpu_ready, 1'b0);
    dwait(20);
    chk("R5 ready restored", cpu_ready, 1'b1);

    // repeated requests with varying busy time
    for (int k = 0; k < 6; k++) begin
      @(negedge cpu_clk) cpu_bus_idle = 0;
      @(negedge dma_clk) hold_req = 1;
      dwait(k * 3 + 1);
      chk("R4 busy no ack", hold_ack, 1'b0);
      @(negedge cpu_clk) cpu_bus_idle = 1;
      seen = 0;
      for (int w = 0; w < 40; w++) begin
        @(negedge dma_clk);
        if (hold_ack) seen = 1;
      end
      chk("R4 ack after idle", seen, 1'b1);
      hold_req = 0;
      @(negedge dma_clk);
      chk("R5 ack drop loop", hold_ack, 1'b0);
      dwait(k % 3);
    end

    // R9 withdrawn request
    dwait(20);
    @(negedge cpu_clk) cpu_bus_idle = 0;
    @(negedge dma_clk) hold_req = 1;
    dwait(3);
    hold_req = 0;
    seen = 0;
    for (int w = 0; w < 15; w++) begin
      @(negedge dma_clk);
      if (hold_ack) seen = 1;
    end
    @(negedge cpu_clk) cpu_bus_idle = 1;
    for (int w = 0; w < 30; w++) begin
      @(negedge dma_clk);
      if (hold_ack) seen = 1;
    end
    chk("R9 no ack on abort", seen, 1'b0);
    chk("R9 ready back", cpu_ready, 1'b1);

    // immediately request again after abort
    hold_req = 1;
    dwait(30);
    chk("R9 fresh grant after abort", hold_ack, 1'b1);
    hold_req = 0;
    dwait(20);
    chk("R1 ready after release", cpu_ready, 1'b1);

    chk("R10 no overlap", (overlaps == 0), 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule